// File: doc/BRIEF.md
# Supply Monitor Reset Controller

This block sits between an analog supply monitor and the rest of a small processor subsystem. It takes two comparator flags (supply below the reset threshold, supply below the early-warning threshold) and produces the core reset, a record of why the last reset happened, a supply-good status bit and a warning interrupt. Software programs two configuration bits: one turns the monitor on, the other lets the monitor act as a reset source. These bits go back to their defaults only on a power-on reset or a supply-failure reset. A software reset leaves them as they were.

A sleep state hides the configuration from the reset logic, so a supply dip during sleep does not destroy retained state. Wake brings back the values software last wrote. A flash program or erase strobe is only allowed while the monitor is both enabled and selected. Otherwise it forces a flash-error reset. Every reset cause holds the core in reset for a programmable number of cycles after the cause goes away. Release is synchronous.

Top module: `supmon_rst_ctrl`

## Requirements
- R1: While `cold_rst_n` is low and right after it rises, the outputs are: `core_rst_o`=1, `rst_cause_o`=0 (power-on), `pwr_rst_flag_o`=1, `mon_en_o`=1, `rst_sel_o`=1, `vdd_ok_o`=1, `warn_irq_o`=0.
- R2: `core_rst_o` stays high for exactly HOLD_CYC clock cycles after the last rising edge at which any reset cause was sampled, and then falls on a clock edge.
- R3: A one-cycle `sw_rst_req_i` asserts reset and records cause 2 (software) with `pwr_rst_flag_o`=0. It leaves `mon_en_o` and `rst_sel_o` unchanged, including the value 0/0.
- R4: When the monitor is enabled and selected, a high `vdd_below_por_i` holds `core_rst_o` high and records cause 1 (supply fail) with `pwr_rst_flag_o`=1. If either configuration bit is 0, the comparator causes no reset.
- R5: While a supply-fail reset is in progress, both configuration bits are held at 1 and configuration writes are ignored.
- R6: A `flash_wr_i` strobe while the effective enable and select bits are not both 1 asserts reset with cause 3 (flash error). With both bits set, the strobe has no effect.
- R7: The cause is captured only when `core_rst_o` rises, and it keeps its value until the next rise. Priority for simultaneous causes is supply fail, then flash error, then software.
- R8: After a `sleep_i` pulse, `mon_en_o` and `rst_sel_o` read 0, the reset comparator causes no reset, and configuration writes are ignored.
- R9: A `wake_i` pulse ends sleep and restores the enable and select values last written before sleep.
- R10: Each comparator input passes through SYNC_STAGES flops. A change of `vdd_below_warn_i` appears on `vdd_ok_o` SYNC_STAGES+1 edges later.
- R11: `vdd_ok_o` is the inverse of the synchronized warning flag. On its falling edge a sticky pending bit is set, and `warn_irq_o` = pending AND `warn_ie_i`.
- R12: A `warn_clr_i` pulse (write of 1) clears the pending bit. If a new warning falls in the same cycle as the clear, the set wins.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| cold_rst_n | input | 1 | Asynchronous power-on reset, active low |
| vdd_below_por_i | input | 1 | Comparator: supply below reset threshold (asynchronous) |
| vdd_below_warn_i | input | 1 | Comparator: supply below warning threshold (asynchronous) |
| sleep_i | input | 1 | One-cycle pulse entering sleep |
| wake_i | input | 1 | One-cycle pulse leaving sleep |
| sw_rst_req_i | input | 1 | Software reset request pulse |
| flash_wr_i | input | 1 | Flash program or erase strobe |
| cfg_we_i | input | 1 | Configuration write enable |
| cfg_mon_en_i | input | 1 | Write data: monitor enable |
| cfg_rst_sel_i | input | 1 | Write data: monitor selected as reset source |
| warn_ie_i | input | 1 | Warning interrupt enable |
| warn_clr_i | input | 1 | Write-1 clear of the warning pending bit |
| core_rst_o | output | 1 | Core reset, active high |
| pwr_rst_flag_o | output | 1 | Last reset was power-on or supply fail |
| rst_cause_o | output | 2 | Last reset cause: 0 power-on, 1 supply fail, 2 software, 3 flash error |
| vdd_ok_o | output | 1 | Supply above warning threshold |
| warn_irq_o | output | 1 | Warning interrupt request |
| mon_en_o | output | 1 | Effective monitor enable |
| rst_sel_o | output | 1 | Effective reset-source select |

## Verification
The configuration bits and the sleep flag appear directly on `mon_en_o` and `rst_sel_o` on the edge after each event, so a wrong retained or restored state shows within one cycle. A wrong hold counter or a wrong synchronizer depth changes the number of cycles `core_rst_o` stays high, or when `vdd_ok_o` moves. The bench counts those cycles exactly. A cause captured at the wrong moment shows on `rst_cause_o` during the reset it belongs to and after it ends.

// File: rtl/supmon_pkg.sv
package supmon_pkg;
   typedef enum logic [1:0] {
      CAUSE_POR   = 2'd0,
      CAUSE_PFAIL = 2'd1,
      CAUSE_SW    = 2'd2,
      CAUSE_FLASH = 2'd3
   } rst_cause_e;
endpackage

// File: rtl/supmon_sync.sv
module supmon_sync #(
   parameter int WIDTH  = 2,
   parameter int STAGES = 2
) (
   input  logic             clk,
   input  logic             arst_n,
   input  logic [WIDTH-1:0] d,
   output logic [WIDTH-1:0] q
);
   if (STAGES < 1) begin : g_bad_stages
      $error("supmon_sync: STAGES must be at least 1");
   end
   if (WIDTH < 1) begin : g_bad_width
      $error("supmon_sync: WIDTH must be at least 1");
   end

   logic [WIDTH-1:0] chain [STAGES];

   always_ff @(posedge clk or negedge arst_n) begin
      if (!arst_n) chain[0] <= '0;
      else         chain[0] <= d;
   end

   if (STAGES > 1) begin : g_chain
      for (genvar s = 1; s < STAGES; s++) begin : g_stage
         always_ff @(posedge clk or negedge arst_n) begin
            if (!arst_n) chain[s] <= '0;
            else         chain[s] <= chain[s-1];
         end
      end
   end

   assign q = chain[STAGES-1];
endmodule

// File: rtl/supmon_cfg.sv
module supmon_cfg (
   input  logic clk,
   input  logic arst_n,
   input  logic force_on,
   input  logic we,
   input  logic en_d,
   input  logic sel_d,
   input  logic sleep_req,
   input  logic wake_req,
   output logic eff_en,
   output logic eff_sel
);
   logic user_en, user_sel, asleep;

   always_ff @(posedge clk or negedge arst_n) begin
      if (!arst_n) begin
         asleep <= 1'b0;
      end else if (wake_req) begin
         asleep <= 1'b0;
      end else if (sleep_req) begin
         asleep <= 1'b1;
      end
   end

   always_ff @(posedge clk or negedge arst_n) begin
      if (!arst_n) begin
         user_en  <= 1'b1;
         user_sel <= 1'b1;
      end else if (force_on) begin
         user_en  <= 1'b1;
         user_sel <= 1'b1;
      end else if (we && !asleep) begin
         user_en  <= en_d;
         user_sel <= sel_d;
      end
   end

   assign eff_en  = user_en  & ~asleep;
   assign eff_sel = user_sel & ~asleep;
endmodule

// File: rtl/supmon_rst_seq.sv
module supmon_rst_seq
   import supmon_pkg::*;
#(
   parameter int HOLD_CYC = 16
) (
   input  logic       clk,
   input  logic       arst_n,
   input  logic       pfail_lvl,
   input  logic       flash_err,
   input  logic       sw_req,
   output logic       core_rst,
   output rst_cause_e cause,
   output logic       pwr_flag
);
   localparam int CNT_W = (HOLD_CYC > 1) ? $clog2(HOLD_CYC) : 1;
   localparam logic [CNT_W-1:0] RELOAD = CNT_W'(HOLD_CYC - 1);

   if (HOLD_CYC < 1) begin : g_bad_hold
      $error("supmon_rst_seq: HOLD_CYC must be at least 1");
   end

   logic [CNT_W-1:0] cnt;
   logic             any_src;
   rst_cause_e       new_cause;

   assign any_src = pfail_lvl | flash_err | sw_req;

   always_comb begin
      if (pfail_lvl)      new_cause = CAUSE_PFAIL;
      else if (flash_err) new_cause = CAUSE_FLASH;
      else                new_cause = CAUSE_SW;
   end

   always_ff @(posedge clk or negedge arst_n) begin
      if (!arst_n) begin
         core_rst <= 1'b1;
         cnt      <= RELOAD;
         cause    <= CAUSE_POR;
         pwr_flag <= 1'b1;
      end else if (any_src) begin
         core_rst <= 1'b1;
         cnt      <= RELOAD;
         if (!core_rst) begin
            cause    <= new_cause;
            pwr_flag <= (new_cause == CAUSE_PFAIL);
         end
      end else if (cnt != '0) begin
         cnt <= cnt - 1'b1;
      end else begin
         core_rst <= 1'b0;
      end
   end
endmodule

// File: rtl/supmon_warn.sv
module supmon_warn (
   input  logic clk,
   input  logic arst_n,
   input  logic below_s,
   input  logic ie,
   input  logic clr,
   output logic vdd_ok,
   output logic irq
);
   logic pend;

   always_ff @(posedge clk or negedge arst_n) begin
      if (!arst_n) begin
         vdd_ok <= 1'b1;
         pend   <= 1'b0;
      end else begin
         vdd_ok <= ~below_s;
         if (vdd_ok && below_s) pend <= 1'b1;
         else if (clr)          pend <= 1'b0;
      end
   end

   assign irq = pend & ie;
endmodule

// File: rtl/supmon_rst_ctrl.sv
module supmon_rst_ctrl
   import supmon_pkg::*;
#(
   parameter int SYNC_STAGES = 2,
   parameter int HOLD_CYC    = 16
) (
   input  logic       clk,
   input  logic       cold_rst_n,
   input  logic       vdd_below_por_i,
   input  logic       vdd_below_warn_i,
   input  logic       sleep_i,
   input  logic       wake_i,
   input  logic       sw_rst_req_i,
   input  logic       flash_wr_i,
   input  logic       cfg_we_i,
   input  logic       cfg_mon_en_i,
   input  logic       cfg_rst_sel_i,
   input  logic       warn_ie_i,
   input  logic       warn_clr_i,
   output logic       core_rst_o,
   output logic       pwr_rst_flag_o,
   output logic [1:0] rst_cause_o,
   output logic       vdd_ok_o,
   output logic       warn_irq_o,
   output logic       mon_en_o,
   output logic       rst_sel_o
);
   localparam int NCMP = 2;

   logic [NCMP-1:0] cmp_s;
   logic            eff_en, eff_sel, armed;
   logic            pfail_lvl, flash_err, pf_busy;
   rst_cause_e      cause;

   supmon_sync #(.WIDTH(NCMP), .STAGES(SYNC_STAGES)) u_sync (
      .clk    (clk),
      .arst_n (cold_rst_n),
      .d      ({vdd_below_warn_i, vdd_below_por_i}),
      .q      (cmp_s)
   );

   assign armed     = eff_en & eff_sel;
   assign pfail_lvl = cmp_s[0] & armed;
   assign flash_err = flash_wr_i & ~armed;
   assign pf_busy   = core_rst_o & (cause == CAUSE_PFAIL);

   supmon_cfg u_cfg (
      .clk       (clk),
      .arst_n    (cold_rst_n),
      .force_on  (pfail_lvl | pf_busy),
      .we        (cfg_we_i),
      .en_d      (cfg_mon_en_i),
      .sel_d     (cfg_rst_sel_i),
      .sleep_req (sleep_i),
      .wake_req  (wake_i),
      .eff_en    (eff_en),
      .eff_sel   (eff_sel)
   );

   supmon_rst_seq #(.HOLD_CYC(HOLD_CYC)) u_seq (
      .clk       (clk),
      .arst_n    (cold_rst_n),
      .pfail_lvl (pfail_lvl),
      .flash_err (flash_err),
      .sw_req    (sw_rst_req_i),
      .core_rst  (core_rst_o),
      .cause     (cause),
      .pwr_flag  (pwr_rst_flag_o)
   );

   supmon_warn u_warn (
      .clk     (clk),
      .arst_n  (cold_rst_n),
      .below_s (cmp_s[1]),
      .ie      (warn_ie_i),
      .clr     (warn_clr_i),
      .vdd_ok  (vdd_ok_o),
      .irq     (warn_irq_o)
   );

   assign rst_cause_o = cause;
   assign mon_en_o    = eff_en;
   assign rst_sel_o   = eff_sel;
endmodule

// File: rtl/supmon_rst_ctrl_chk.sv
module supmon_rst_ctrl_chk #(
   parameter int HOLD_CYC = 16
) (
   input logic       clk,
   input logic       cold_rst_n,
   input logic       sleep_i,
   input logic       wake_i,
   input logic       sw_rst_req_i,
   input logic       flash_wr_i,
   input logic       cfg_we_i,
   input logic       warn_ie_i,
   input logic       core_rst_o,
   input logic       pwr_rst_flag_o,
   input logic [1:0] rst_cause_o,
   input logic       vdd_ok_o,
   input logic       warn_irq_o,
   input logic       mon_en_o,
   input logic       rst_sel_o
);
   logic [31:0] high_cnt;

   always_ff @(posedge clk or negedge cold_rst_n) begin
      if (!cold_rst_n)     high_cnt <= '0;
      else if (core_rst_o) high_cnt <= (high_cnt == 32'hFFFF_FFFF) ? high_cnt : high_cnt + 1;
      else                 high_cnt <= '0;
   end

   // R2
   min_hold_chk: assert property (@(posedge clk) disable iff (!cold_rst_n)
      $fell(core_rst_o) |-> (high_cnt >= HOLD_CYC));

   // R3
   sw_keeps_cfg_chk: assert property (@(posedge clk) disable iff (!cold_rst_n)
      (sw_rst_req_i && !cfg_we_i && !sleep_i && !wake_i && !core_rst_o)
      |=> $stable({mon_en_o, rst_sel_o}));

   // R6
   flash_err_rst_chk: assert property (@(posedge clk) disable iff (!cold_rst_n)
      (flash_wr_i && !(mon_en_o && rst_sel_o) && !core_rst_o)
      |=> (core_rst_o && rst_cause_o == 2'd3));

   // R7
   cause_hold_chk: assert property (@(posedge clk) disable iff (!cold_rst_n)
      !$rose(core_rst_o) |-> $stable(rst_cause_o));

   // R4
   pwr_flag_chk: assert property (@(posedge clk) disable iff (!cold_rst_n)
      pwr_rst_flag_o == (rst_cause_o <= 2'd1));

   // R8
   idle_when_off_chk: assert property (@(posedge clk) disable iff (!cold_rst_n)
      (!mon_en_o && !core_rst_o && !sw_rst_req_i && !flash_wr_i) |=> !core_rst_o);

   // R11
   warn_irq_chk: assert property (@(posedge clk) disable iff (!cold_rst_n)
      ($fell(vdd_ok_o) && warn_ie_i) |-> warn_irq_o);
endmodule

bind supmon_rst_ctrl supmon_rst_ctrl_chk #(.HOLD_CYC(HOLD_CYC)) u_chk (
   .clk            (clk),
   .cold_rst_n     (cold_rst_n),
   .sleep_i        (sleep_i),
   .wake_i         (wake_i),
   .sw_rst_req_i   (sw_rst_req_i),
   .flash_wr_i     (flash_wr_i),
   .cfg_we_i       (cfg_we_i),
   .warn_ie_i      (warn_ie_i),
   .core_rst_o     (core_rst_o),
   .pwr_rst_flag_o (pwr_rst_flag_o),
   .rst_cause_o    (rst_cause_o),
   .vdd_ok_o       (vdd_ok_o),
   .warn_irq_o     (warn_irq_o),
   .mon_en_o       (mon_en_o),
   .rst_sel_o      (rst_sel_o)
);

// File: tb/supmon_rst_ctrl_test.sv
`timescale 1ns/1ps
module supmon_rst_ctrl_test;
   localparam int STG  = 2;
   localparam int HOLD = 5;

   logic clk = 1'b0;
   logic cold_rst_n = 1'b0;
   logic below_por = 1'b0, below_warn = 1'b0, slp = 1'b0, wk = 1'b0;
   logic swr = 1'b0, fwr = 1'b0, we = 1'b0, en_d = 1'b0, sel_d = 1'b0;
   logic ie = 1'b0, clr = 1'b0;
   logic core_rst, pflag, vok, irq, men, rsel;
   logic [1:0] cause;

   int n_chk = 0;
   int n_fail = 0;
   bit done = 1'b0;

   always #5 clk = ~clk;

   supmon_rst_ctrl #(.SYNC_STAGES(STG), .HOLD_CYC(HOLD)) uut (
      .clk(clk), .cold_rst_n(cold_rst_n),
      .vdd_below_por_i(below_por), .vdd_below_warn_i(below_warn),
      .sleep_i(slp), .wake_i(wk), .sw_rst_req_i(swr), .flash_wr_i(fwr),
      .cfg_we_i(we), .cfg_mon_en_i(en_d), .cfg_rst_sel_i(sel_d),
      .warn_ie_i(ie), .warn_clr_i(clr),
      .core_rst_o(core_rst), .pwr_rst_flag_o(pflag), .rst_cause_o(cause),
      .vdd_ok_o(vok), .warn_irq_o(irq), .mon_en_o(men), .rst_sel_o(rsel)
   );

   task automatic chk(input string req, input int act, input int exp);
      n_chk++;
      if (act != exp) begin
         n_fail++;
         $display("FAIL %s: actual %0d expected %0d", req, act, exp);
      end
   endtask

   task automatic tick(input int n);
      repeat (n) @(negedge clk);
   endtask

   task automatic wcfg(input logic e, input logic s);
      en_d = e; sel_d = s; we = 1'b1;
      tick(1);
      we = 1'b0;
   endtask

   task automatic pulse_sw();
      swr = 1'b1; tick(1); swr = 1'b0;
   endtask

   task automatic pulse_flash();
      fwr = 1'b1; tick(1); fwr = 1'b0;
   endtask

   // counts negedge samples with core_rst high, starting now
   task automatic high_len(output int n);
      n = 0;
      while (core_rst && n < 1000) begin
         n++;
         tick(1);
      end
   endtask

   initial begin
      int len;
      tick(3);
      // R1 reset state
      chk("R1 core_rst", core_rst, 1);
      chk("R1 cause", cause, 0);
      chk("R1 pwr_flag", pflag, 1);
      chk("R1 mon_en", men, 1);
      chk("R1 rst_sel", rsel, 1);
      chk("R1 vdd_ok", vok, 1);
      chk("R1 irq", irq, 0);
      cold_rst_n = 1'b1;
      high_len(len);
      chk("R2 hold after cold reset", len, HOLD);
      chk("R1 cause after release", cause, 0);

      // R3 software reset with several configurations, R2 exact hold
      for (int c = 0; c < 4; c++) begin
         wcfg(c[0], c[1]);
         tick(1);
         pulse_sw();
         chk("R3 cause sw", cause, 2);
         chk("R3 pwr_flag", pflag, 0);
         high_len(len);
         chk("R2 hold after sw", len, HOLD);
         chk("R3 mon_en kept", men, c[0]);
         chk("R3 rst_sel kept", rsel, c[1]);
      end

      // R6 flash strobe over all enable/select combinations
      for (int c = 0; c < 4; c++) begin
         wcfg(c[0], c[1]);
         tick(1);
         pulse_flash();
         chk("R6 flash reset", core_rst, (c == 3) ? 0 : 1);
         if (c != 3) begin
            chk("R6 cause flash", cause, 3);
            high_len(len);
            chk("R2 hold after flash", len, HOLD);
         end else begin
            tick(3);
            chk("R6 no reset when armed", core_rst, 0);
            chk("R6 cause unchanged", cause, 3);
         end
      end

      // R7 priority flash over software, and cause frozen during reset
      wcfg(0, 0);
      tick(1);
      swr = 1'b1; fwr = 1'b1; tick(1); swr = 1'b0; fwr = 1'b0;
      chk("R7 flash beats sw", cause, 3);
      tick(2);
      pulse_sw();
      chk("R7 cause held in reset", cause, 3);
      high_len(len);
      chk("R2 hold restarted by late cause", len, HOLD);
      chk("R7 cause after release", cause, 3);

      // R4 supply fail while armed
      wcfg(1, 1);
      tick(1);
      below_por = 1'b1;
      tick(STG + 1);
      chk("R4 pfail reset", core_rst, 1);
      chk("R4 cause pfail", cause, 1);
      chk("R4 pwr_flag", pflag, 1);
      wcfg(0, 0);   // R5 write during supply-fail reset
      tick(10);
      chk("R4 held while low", core_rst, 1);
      chk("R5 mon_en forced", men, 1);
      chk("R5 rst_sel forced", rsel, 1);
      below_por = 1'b0;
      high_len(len);
      chk("R2 hold after pfail", len, HOLD + STG);
      chk("R5 cfg after pfail en", men, 1);
      chk("R5 cfg after pfail sel", rsel, 1);

      // R4 comparator ignored unless both bits set
      for (int c = 0; c < 3; c++) begin
         wcfg(c[0], c[1]);
         below_por = 1'b1;
         tick(8);
         chk("R4 not armed no reset", core_rst, 0);
         below_por = 1'b0;
         tick(STG + 1);
      end
      chk("R4 cause unchanged", cause, 1);

      // R8/R9 sleep masks and wake restores
      for (int c = 1; c < 4; c++) begin
         wcfg(c[0], c[1]);
         slp = 1'b1; tick(1); slp = 1'b0;
         chk("R8 mon_en masked", men, 0);
         chk("R8 rst_sel masked", rsel, 0);
         wcfg(~c[0], ~c[1]);
         below_por = 1'b1;
         tick(8);
         chk("R8 no pfail in sleep", core_rst, 0);
         below_por = 1'b0;
         tick(STG + 1);
         wk = 1'b1; tick(1); wk = 1'b0;
         chk("R9 mon_en restored", men, c[0]);
         chk("R9 rst_sel restored", rsel, c[1]);
      end

      // R10/R11 warning path
      ie = 1'b1;
      below_warn = 1'b1;
      tick(STG);
      chk("R10 vdd_ok not yet", vok, 1);
      tick(1);
      chk("R10 vdd_ok cleared", vok, 0);
      chk("R11 irq raised", irq, 1);
      ie = 1'b0; tick(1);
      chk("R11 irq masked", irq, 0);
      ie = 1'b1; tick(1);
      chk("R11 irq pending kept", irq, 1);
      clr = 1'b1; tick(1); clr = 1'b0;
      chk("R12 cleared", irq, 0);
      tick(3);
      chk("R12 no re-raise while low", irq, 0);
      below_warn = 1'b0;
      tick(STG + 1);
      chk("R11 vdd_ok back", vok, 1);
      chk("R11 no irq on rise", irq, 0);
      // R12 set wins over clear
      below_warn = 1'b1;
      tick(STG);
      clr = 1'b1; tick(1); clr = 1'b0;
      chk("R12 set beats clear", irq, 1);
      chk("R12 vdd_ok low", vok, 0);
      below_warn = 1'b0;
      tick(4);

      done = 1'b1;
      $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
      $finish;
   end

   initial begin
      repeat (20000) @(posedge clk);
      if (!done) begin
         n_fail++;
         $display("FAIL watchdog: actual timeout expected completion");
         $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
         $finish;
      end
   end
endmodule